// File: doc/BRIEF.md
# Pulse Accumulator Counter

This block is an 8-bit counter driven by one external input line. It has two modes. In event mode it adds one for each selected transition on the line. In gated mode it counts a slow internal time base, made by dividing a clock-enable input by 64, for as long as the line sits at its active level. Software can load the counter in any cycle through a write port, and the current value is always visible on an output. This works even while counting is in progress.

Two sticky flags report activity. One flag marks a wrap from 0xFF to 0x00. The other marks an input event: a counted transition in event mode, or the end of an active gate period in gated mode. Each flag has its own clear strobe and its own interrupt enable. A single polarity bit serves both modes. In event mode it picks the edge direction, and in gated mode it picks the active level. The input line passes through a two-flop synchroniser before any detection.

Top module: `pulse_acc`

## Requirements
- R1: While rst_n is low, count, both flags and both interrupt outputs are 0.
- R2: Event mode (cfg_enable=1, cfg_gated=0) counts edges on pin_in. The edge is rising when cfg_pol=0 and falling when cfg_pol=1. A pin change made between clock edges shows in count after the third following rising clock edge.
- R3: Gated mode (cfg_enable=1, cfg_gated=1) treats the synchronised pin as open when it is high (cfg_pol=0) or low (cfg_pol=1). While the gate is open, count advances by one on every 64th tick_en pulse. The prescaler holds its value while the gate is closed, and it clears when the block is disabled or in event mode.
- R4: With cfg_enable=0, pin activity changes neither count nor either flag.
- R5: wr_en=1 loads wr_data into count at the next clock edge, in any mode. It takes priority over an increment in the same cycle, and that increment is lost without setting the overflow flag.
- R6: ovf_flag is set when an increment takes count from 0xFF to 0x00. It stays set until an ovf_clr pulse. If a set and a clear fall in the same cycle, the set wins.
- R7: edge_flag is set on every selected edge in event mode and on each gate closing in gated mode. It is cleared by edge_clr, and a set wins over a clear in the same cycle.
- R8: irq_ovf equals ovf_flag AND ovf_ie, and irq_edge equals edge_flag AND edge_ie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-base enable fed to the gated-mode prescaler |
| pin_in | input | 1 | Asynchronous counter input line |
| cfg_enable | input | 1 | Block enable |
| cfg_gated | input | 1 | 0 = event mode, 1 = gated mode |
| cfg_pol | input | 1 | Edge select (event mode) or active level select (gated mode) |
| wr_en | input | 1 | Counter load strobe |
| wr_data | input | 8 | Counter load value |
| ovf_clr | input | 1 | Clears ovf_flag |
| edge_clr | input | 1 | Clears edge_flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| edge_ie | input | 1 | Input-event interrupt enable |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| edge_flag | output | 1 | Sticky input-event flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-event interrupt request |

## Verification
The assertions assume that the configuration inputs change only between clock edges. They also assume that tick_en is a plain single-cycle strobe with no link to the pin. The stimulus therefore changes mode and polarity only at phase boundaries, and it drives every input just after the falling clock edge. The pin toggles at random and also holds for long runs, so open gates cross many 64-tick windows. Loads of 0xFE and 0xFF are mixed in to force wraps and collisions between a load and an increment.

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CW  = 8,
  parameter int PRE = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          pin_in,
  input  logic          cfg_enable,
  input  logic          cfg_gated,
  input  logic          cfg_pol,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          ovf_clr,
  input  logic          edge_clr,
  input  logic          ovf_ie,
  input  logic          edge_ie,
  output logic [CW-1:0] count,
  output logic          ovf_flag,
  output logic          edge_flag,
  output logic          irq_ovf,
  output logic          irq_edge
);
  localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE - 1);

  logic s1, s2, s3;
  logic [PW-1:0] pre;

  wire gate_now  = s2 ^ cfg_pol;
  wire gate_was  = s3 ^ cfg_pol;
  wire sel_edge  = cfg_pol ? (s3 & ~s2) : (s2 & ~s3);
  wire pre_wrap  = tick_en && (pre == PRE_LAST);
  wire bump      = cfg_enable && (cfg_gated ? (gate_now && pre_wrap) : sel_edge);
  wire edge_evt  = cfg_enable && (cfg_gated ? (gate_was && !gate_now) : sel_edge);
  wire wrap      = bump && !wr_en && (count == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {pin_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       pre <= '0;
    else if (!cfg_enable || !cfg_gated) pre <= '0;
    else if (gate_now && tick_en)     pre <= pre_wrap ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wr_data;
    else if (bump)  count <= count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        edge_flag <= 1'b0;
    else if (edge_evt) edge_flag <= 1'b1;
    else if (edge_clr) edge_flag <= 1'b0;

  assign irq_ovf  = ovf_flag & ovf_ie;
  assign irq_edge = edge_flag & edge_ie;

  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !wr_en) |=> $stable(count));

  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (count == $past(count) || count == $past(count) + 1'b1));

  p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_gated && !gate_now && !wr_en) |=> $stable(count));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count == '0 && $past(count) == {CW{1'b1}}));

  p_edge_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !edge_clr) |=> $stable(edge_flag));
endmodule

// File: tb/test_pulse_acc.sv
module test_pulse_acc;
  logic clk = 0, rst_n = 0;
  logic tick_en = 0, pin_in = 0, cfg_enable = 0, cfg_gated = 0, cfg_pol = 0;
  logic wr_en = 0, ovf_clr = 0, edge_clr = 0, ovf_ie = 0, edge_ie = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count;
  logic ovf_flag, edge_flag, irq_ovf, irq_edge;

  int n_tests = 0, n_fail = 0;
  logic m_s1 = 0, m_s2 = 0, m_s3 = 0;
  int   m_pre = 0;
  logic [7:0] m_cnt = 0;
  logic m_ovf = 0, m_edg = 0;
  logic last_wr = 0;

  always #2 clk = ~clk;

  pulse_acc i_pulse_acc (.*);

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic sel_edge_f(logic a, logic b, logic pol);
    return pol ? (b & ~a) : (a & ~b);
  endfunction

  task automatic model_step();
    logic gn, gw, se, wrap_pre, bump, evt;
    gn = m_s2 ^ cfg_pol;
    gw = m_s3 ^ cfg_pol;
    se = sel_edge_f(m_s2, m_s3, cfg_pol);
    wrap_pre = tick_en && (m_pre == 63);
    bump = cfg_enable && (cfg_gated ? (gn && wrap_pre) : se);
    evt  = cfg_enable && (cfg_gated ? (gw && !gn) : se);
    if (bump && !wr_en && m_cnt == 8'hFF) m_ovf = 1;
    else if (ovf_clr) m_ovf = 0;
    if (evt) m_edg = 1;
    else if (edge_clr) m_edg = 0;
    if (wr_en) m_cnt = wr_data;
    else if (bump) m_cnt = m_cnt + 8'd1;
    if (!cfg_enable || !cfg_gated) m_pre = 0;
    else if (gn && tick_en) m_pre = wrap_pre ? 0 : m_pre + 1;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    last_wr = wr_en;
  endtask

  task automatic compare_all();
    string rc;
    rc = last_wr ? "R5" : (!cfg_enable ? "R4" : (cfg_gated ? "R3" : "R2"));
    check(rc, count, m_cnt);
    check("R6", ovf_flag, m_ovf);
    check(cfg_enable ? "R7" : "R4", edge_flag, m_edg);
    check("R8", irq_ovf, m_ovf & ovf_ie);
    check("R8", irq_edge, m_edg & edge_ie);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_phase(int n, bit en, bit gated, bit pol, int pin_hold);
    cfg_enable = en; cfg_gated = gated; cfg_pol = pol;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(pin_hold) == 0) pin_in = ~pin_in;
      tick_en  = ($urandom_range(3) != 0);
      wr_en    = ($urandom_range(60) == 0);
      case ($urandom_range(3))
        0: wr_data = 8'hFF;
        1: wr_data = 8'hFE;
        default: wr_data = 8'($urandom);
      endcase
      ovf_clr  = ($urandom_range(40) == 0);
      edge_clr = ($urandom_range(10) == 0);
      ovf_ie   = ($urandom_range(1) == 1);
      edge_ie  = ($urandom_range(1) == 1);
      cycle();
    end
    wr_en = 0; ovf_clr = 0; edge_clr = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    pin_in = 1; ovf_ie = 1; edge_ie = 1;
    @(negedge clk);
    check("R1", count, 0); check("R1", ovf_flag, 0); check("R1", edge_flag, 0);
    check("R1", irq_ovf, 0); check("R1", irq_edge, 0);
    pin_in = 0;
    rst_n = 1;
    cycle();

    // R2 directed: one rising edge shows after the third rising clock edge
    cfg_enable = 1; wr_en = 1; wr_data = 8'hFF; cycle(); wr_en = 0;
    pin_in = 1;
    cycle(); check("R2", count, 8'hFF);
    cycle(); check("R2", count, 8'hFF);
    cycle(); check("R2", count, 8'h00); check("R6", ovf_flag, 1);
    check("R7", edge_flag, 1);

    // R5 directed: load collides with an increment
    pin_in = 0; repeat (3) cycle();
    wr_data = 8'hFF; wr_en = 1; cycle(); wr_en = 0;
    ovf_clr = 1; cycle(); ovf_clr = 0;
    pin_in = 1; cycle(); cycle();
    wr_en = 1; wr_data = 8'h42; cycle(); wr_en = 0;
    check("R5", count, 8'h42); check("R5", ovf_flag, 0);

    // R6: set wins over a clear in the same cycle
    wr_en = 1; wr_data = 8'hFF; cycle(); wr_en = 0;
    pin_in = 0; cycle(); cycle(); cycle();
    pin_in = 1; cycle(); cycle(); ovf_clr = 1; cycle(); ovf_clr = 0;
    check("R6", ovf_flag, 1);

    run_phase(500, 1, 0, 0, 3);
    run_phase(500, 1, 0, 1, 3);
    run_phase(300, 0, 0, 0, 2);
    run_phase(1500, 1, 1, 0, 150);
    run_phase(1500, 1, 1, 1, 150);
    run_phase(300, 0, 1, 0, 2);
    run_phase(600, 1, 1, 0, 8);
    run_phase(400, 1, 0, 1, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule